// File: doc/BRIEF.md
# Dual-Channel ADC Sample Packer

This block takes a pair of 12-bit converter samples on each qualified clock cycle, one from channel A and one from channel B. Each sample is widened to a 16-bit slot. A mode input chooses whether the sample sits at the top of the slot (left) or at the bottom (right). Two pairs form one 64-bit word, with the channels interleaved. The block then queues the word for a downstream consumer.

The consumer sees a data bus and a valid strobe, and it can hold delivery back with a stop input. The converter side runs freely and cannot be stalled. Completed words therefore wait in a small FIFO. A word that finds no room is discarded, and a sticky overflow flag records the loss until software pulses a clear input.

Top module: `adc_pair_packer`

## Requirements
- R1: A sample pair on `smp_a`/`smp_b` is taken only on a cycle with `in_valid` high. Values present while `in_valid` is low leave no trace in any output word.
- R2: When `left_just` is 1, the 12-bit sample goes in slot bits [15:4] and bits [3:0] are zero. When it is 0, the sample goes in bits [11:0] and bits [15:12] are zero, with no sign extension. The mode is sampled together with each pair.
- R3: Inside a 64-bit word, bits [15:0] hold A of the first pair, [31:16] hold B of the first pair, [47:32] hold A of the second pair and [63:48] hold B of the second pair.
- R4: A word is queued only when its second pair is accepted. A single pair on its own produces no output.
- R5: While `stop` is high, `out_valid` is low. Every cycle in which `out_valid` is high delivers `out_data` and removes it from the queue.
- R6: Up to 8 completed words are held, and they are delivered in the order they were completed. `out_valid` stays low when nothing is queued.
- R7: A word completed while the queue holds 8 words, with no word leaving in the same cycle, is discarded, and `ovf_flag` rises on the next cycle.
- R8: `ovf_flag` stays high until a cycle with `ovf_clear` high and no discard. If a discard and a clear happen in the same cycle, the flag stays set.
- R9: A synchronous `rst` empties the queue, clears `ovf_flag`, drops any half-built word, and restarts packing with the first pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample pair qualifier |
| smp_a | input | 12 | Channel A sample |
| smp_b | input | 12 | Channel B sample |
| left_just | input | 1 | 1 = left-justify in slot, 0 = right-justify |
| stop | input | 1 | Consumer hold request |
| ovf_clear | input | 1 | Clears the overflow flag |
| out_data | output | 64 | Packed word |
| out_valid | output | 1 | Word on `out_data` is delivered this cycle |
| ovf_flag | output | 1 | Sticky word-loss indicator |

## Verification
The packer is fed streams of pairs in several forms:
- Back-to-back pairs.
- Pairs separated by idle cycles that carry garbage data. This separates correct qualification from capture of stray values.
- Mixed justification within one word. This tells apart per-pair sampling of the mode from per-word sampling.

Distinct values in all four slots expose any swapped channel or slot. Holding `stop` while nine words complete fills the queue and forces exactly one discard. Releasing `stop` then shows whether order is kept and whether the discarded word stays out of the stream. A reset between the halves of a word shows whether packing restarts at the first slot.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;
  localparam int SMP_W   = 12;
  localparam int SLOT_W  = 16;
  localparam int PAIR_W  = 2 * SLOT_W;
  localparam int PAIRS   = 2;
  localparam int WORD_W  = PAIR_W * PAIRS;
  localparam int PAD_W   = SLOT_W - SMP_W;

  // Place a raw sample into a 16-bit slot, top- or bottom-aligned.
  function automatic logic [SLOT_W-1:0] place_sample(input logic [SMP_W-1:0] s,
                                                     input logic left);
    if (left) place_sample = {s, {PAD_W{1'b0}}};
    else      place_sample = {{PAD_W{1'b0}}, s};
  endfunction
endpackage

// File: rtl/adc_pack_lane.sv
module adc_pack_lane
  import adc_pack_pkg::*;
(
  input  logic [SMP_W-1:0]  raw,
  input  logic              left,
  output logic [SLOT_W-1:0] slot
);
  assign slot = place_sample(raw, left);
endmodule

// File: rtl/adc_pack_asm.sv
module adc_pack_asm
  import adc_pack_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PAIR_W-1:0] pair,
  output logic              word_push,
  output logic [WORD_W-1:0] word_data,
  output logic              half
);
  logic              half_q;
  logic [PAIR_W-1:0] first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q  <= 1'b0;
      first_q <= '0;
    end else if (in_valid) begin
      if (!half_q) first_q <= pair;
      half_q <= ~half_q;
    end
  end

  assign word_push = in_valid & half_q;
  assign word_data = {pair, first_q};
  assign half      = half_q;
endmodule

// File: rtl/adc_pack_fifo.sv
module adc_pack_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          drop,
  output logic [CW-1:0] cnt
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, accept, do_pop;

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign do_pop = pop & ~empty;
  assign accept = push & (~full | do_pop);
  assign drop   = push & full & ~do_pop;
  assign dout   = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    nxt = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (accept) wr_ptr <= nxt(wr_ptr);
      if (do_pop) rd_ptr <= nxt(rd_ptr);
      cnt <= cnt + CW'(accept) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/adc_pair_packer.sv
module adc_pair_packer
  import adc_pack_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SMP_W-1:0]  smp_a,
  input  logic [SMP_W-1:0]  smp_b,
  input  logic              left_just,
  input  logic              stop,
  input  logic              ovf_clear,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              ovf_flag
);
  logic [SMP_W-1:0]  raw_s  [2];
  logic [SLOT_W-1:0] slot_s [2];
  logic [PAIR_W-1:0] pair;
  logic              word_push, word_drop, half, fifo_empty;
  logic [WORD_W-1:0] word_data;
  logic [CW-1:0]     fifo_cnt;

  assign raw_s[0] = smp_a;
  assign raw_s[1] = smp_b;

  for (genvar ch = 0; ch < 2; ch++) begin : g_lane
    adc_pack_lane u_lane (.raw(raw_s[ch]), .left(left_just), .slot(slot_s[ch]));
  end

  assign pair = {slot_s[1], slot_s[0]};

  adc_pack_asm u_asm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pair(pair),
    .word_push(word_push), .word_data(word_data), .half(half)
  );

  adc_pack_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(word_push), .din(word_data),
    .pop(out_valid), .dout(out_data), .empty(fifo_empty),
    .drop(word_drop), .cnt(fifo_cnt)
  );

  assign out_valid = ~fifo_empty & ~stop;

  always_ff @(posedge clk) begin
    if (rst)            ovf_flag <= 1'b0;
    else if (word_drop) ovf_flag <= 1'b1;
    else if (ovf_clear) ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/adc_pair_packer_chk.sv
module adc_pair_packer_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          stop,
  input logic          out_valid,
  input logic          ovf_flag,
  input logic          ovf_clear,
  input logic          word_push,
  input logic          word_drop,
  input logic          half,
  input logic [CW-1:0] fifo_cnt
);
  p_stop_gates_valid_r5: assert property (@(posedge clk) disable iff (rst)
    stop |-> !out_valid);
  p_empty_no_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (fifo_cnt == '0) |-> !out_valid);
  p_depth_bound_r6: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CW'(DEPTH));
  p_push_restarts_r4: assert property (@(posedge clk) disable iff (rst)
    word_push |=> !half);
  p_drop_only_full_r7: assert property (@(posedge clk) disable iff (rst)
    word_drop |-> (fifo_cnt == CW'(DEPTH)));
  p_drop_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
    word_drop |=> ovf_flag);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clear) |=> ovf_flag);
  p_clear_works_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_clear && !word_drop) |=> !ovf_flag);
endmodule

bind adc_pair_packer adc_pair_packer_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .stop(stop), .out_valid(out_valid),
  .ovf_flag(ovf_flag), .ovf_clear(ovf_clear), .word_push(word_push),
  .word_drop(word_drop), .half(half), .fifo_cnt(fifo_cnt)
);

// File: tb/adc_pair_packer_tb.sv
`timescale 1ns/1ps
module adc_pair_packer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] smp_a = '0, smp_b = '0;
  logic        left_just = 1'b0;
  logic        stop = 1'b0;
  logic        ovf_clear = 1'b0;
  logic [63:0] out_data;
  logic        out_valid, ovf_flag;

  int errors = 0;
  int checks = 0;
  logic [63:0] exp_q[$];

  always #2.5 clk = ~clk;

  adc_pair_packer u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .smp_a(smp_a), .smp_b(smp_b),
    .left_just(left_just), .stop(stop), .ovf_clear(ovf_clear),
    .out_data(out_data), .out_valid(out_valid), .ovf_flag(ovf_flag)
  );

  function automatic logic [63:0] slot_of(logic [11:0] s, bit lj);
    logic [63:0] v = 64'(s);
    return lj ? (v << 4) : v;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0;
      smp_a = 12'($urandom);
      smp_b = 12'($urandom);
      left_just = 1'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic send_pair(logic [11:0] a, logic [11:0] b, bit lj);
    in_valid = 1'b1; smp_a = a; smp_b = b; left_just = lj;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Driver: expected word is built from R2/R3 with shifts and pushed to the scoreboard.
  task automatic send_word(logic [11:0] a0, logic [11:0] b0, logic [11:0] a1,
                           logic [11:0] b1, bit lj0, bit lj1, int gap, bit keep);
    logic [63:0] w;
    w = slot_of(a0, lj0) | (slot_of(b0, lj0) << 16) |
        (slot_of(a1, lj1) << 32) | (slot_of(b1, lj1) << 48);
    if (keep) exp_q.push_back(w);
    send_pair(a0, b0, lj0);
    idle(gap);
    send_pair(a1, b1, lj1);
  endtask

  // Monitor: compares each delivered word against the scoreboard (R3, R5, R6).
  always @(negedge clk) begin
    if (!rst) begin
      if (stop && out_valid) chk(1'b0, "R5 valid while stop", 64'(out_valid), 64'd0);
      if (out_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected word", out_data, 64'd0);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R3 word content/order", out_data, e);
        end
      end
    end
  end

  task automatic drain_check(string req);
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0, "R9 reset out_valid", 64'(out_valid), 64'd0);
    chk(ovf_flag == 1'b0, "R9 reset ovf_flag", 64'(ovf_flag), 64'd0);

    // R2 right and left justification, R3 slot order, back-to-back
    send_word(12'h123, 12'h456, 12'h789, 12'hABC, 1'b0, 1'b0, 0, 1'b1);
    send_word(12'hFED, 12'h001, 12'h800, 12'h7FF, 1'b1, 1'b1, 0, 1'b1);
    // R2 mode sampled per pair
    send_word(12'h5A5, 12'hA5A, 12'h3C3, 12'hC3C, 1'b1, 1'b0, 0, 1'b1);
    drain_check("R3 basic words delivered");

    // R1: garbage on idle cycles between and around pairs
    idle(3);
    send_word(12'h111, 12'h222, 12'h333, 12'h444, 1'b0, 1'b1, 4, 1'b1);
    idle(2);
    send_word(12'hAAA, 12'hBBB, 12'hCCC, 12'hDDD, 1'b1, 1'b0, 1, 1'b1);
    drain_check("R1 gaps ignored");

    // R4: a single pair alone produces nothing
    send_pair(12'h0F0, 12'h0E0, 1'b0);
    idle(4);
    chk(out_valid == 1'b0, "R4 half word not output", 64'(out_valid), 64'd0);
    // finish that word with the second pair
    exp_q.push_back(slot_of(12'h0F0, 0) | (slot_of(12'h0E0, 0) << 16) |
                    (slot_of(12'h0D0, 0) << 32) | (slot_of(12'h0C0, 0) << 48));
    send_pair(12'h0D0, 12'h0C0, 1'b0);
    drain_check("R4 word after second pair");

    // R5: stop holds words back while more arrive
    stop = 1'b1;
    send_word(12'h010, 12'h020, 12'h030, 12'h040, 1'b0, 1'b0, 0, 1'b1);
    send_word(12'h050, 12'h060, 12'h070, 12'h080, 1'b1, 1'b1, 0, 1'b1);
    idle(2);
    chk(out_valid == 1'b0, "R5 stop blocks", 64'(out_valid), 64'd0);
    stop = 1'b0;
    drain_check("R5 words released after stop");

    // R6/R7: fill 8 words under stop, the ninth is dropped
    stop = 1'b1;
    for (int k = 0; k < 9; k++)
      send_word(12'(k * 16 + 1), 12'(k * 16 + 2), 12'(k * 16 + 3), 12'(k * 16 + 4),
                k[0], ~k[0], 0, k < 8);
    chk(ovf_flag == 1'b1, "R7 overflow flag set", 64'(ovf_flag), 64'd1);
    chk(out_valid == 1'b0, "R5 stop holds full queue", 64'(out_valid), 64'd0);
    stop = 1'b0;
    drain_check("R6 eight words in order, dropped word absent");
    chk(out_valid == 1'b0, "R6 empty after drain", 64'(out_valid), 64'd0);
    // R8: sticky until cleared
    idle(3);
    chk(ovf_flag == 1'b1, "R8 flag sticky", 64'(ovf_flag), 64'd1);
    ovf_clear = 1'b1;
    @(negedge clk);
    ovf_clear = 1'b0;
    chk(ovf_flag == 1'b0, "R8 flag cleared", 64'(ovf_flag), 64'd0);

    // R9: reset mid-word restarts at the first slot, and clears the flag
    stop = 1'b1;
    for (int k = 0; k < 9; k++)
      send_word(12'h0AB, 12'h0CD, 12'h0EF, 12'h012, 1'b0, 1'b0, 0, 1'b0);
    send_pair(12'hBAD, 12'hBAD, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    stop = 1'b0;
    @(negedge clk);
    chk(ovf_flag == 1'b0, "R9 reset clears flag", 64'(ovf_flag), 64'd0);
    chk(out_valid == 1'b0, "R9 reset empties queue", 64'(out_valid), 64'd0);
    send_word(12'h321, 12'h654, 12'h987, 12'hCBA, 1'b1, 1'b0, 0, 1'b1);
    drain_check("R9 packing restarts after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule